// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a single 32-bit down counter behind a small word-addressed register bus. A count-enable strobe from elsewhere in the chip is divided by a selectable prescaler (1, 16 or 256). The result steps the counter whenever the timer is enabled. The counter runs as a 16-bit or a 32-bit counter. It has three modes. Free-running mode wraps to the all-ones value of the selected width. Periodic mode reloads from a programmed value. One-shot mode parks at zero.

Each time the counter steps from one to zero, a sticky raw interrupt flag is set. Software clears that flag by writing to a clear register. The interrupt pin is the raw flag qualified by an interrupt-enable bit. Software can set the reload value in two ways. An immediate load also restarts the counter from that value. A deferred load only replaces the value used at the next wrap.

Reads are combinational from the registered state. Writes take effect at the clock edge on which `bus_wr` is high.

Top module: `interval_timer`

## Requirements
- R1: After reset, control (word 2) reads 0x20, meaning interrupts enabled, timer stopped, free-running, 16-bit and prescale by 1. The counter (word 1), the reload value (word 0) and the raw status (word 4) read 0, and `irq` is low.
- R2: The word offset map is:
  - word 0 is the immediate load;
  - word 1 is the counter;
  - word 2 is the control register, in which bit 0 selects one-shot, bit 1 selects 32-bit, bits 3:2 select the prescaler, bit 5 enables the interrupt, bit 6 selects periodic and bit 7 enables the timer;
  - word 3 is the interrupt clear;
  - word 4 is the raw status in bit 0;
  - word 5 is the masked status in bit 0;
  - word 6 is the deferred load.

  Words 0 and 6 both read the stored reload value. Reads at words 3 and 7 return 0.
- R3: The prescaler field takes these values: 00 makes one counter step per strobe, 01 one step per 16 strobes, 10 one step per 256 strobes, and 11 behaves as 00. Any control write restarts the prescaler phase, so after it the counter steps on the 1st, 16th or 256th strobe.
- R4: A write to word 0 stores the reload value and puts it, cut to the current width, into the counter on the same edge.
- R5: A write to word 6 changes only the stored reload value. The counter keeps counting and takes the new value at its next wrap. Writes to word 1 are ignored.
- R6: In free-running mode, a step taken at zero loads 0xFFFF in 16-bit mode and 0xFFFFFFFF in 32-bit mode.
- R7: In periodic mode, a step taken at zero loads the stored reload value, so a reload value of L gives a period of L+1 steps.
- R8: In 16-bit mode, bits 31:16 of the counter read as zero. Loads are cut to 16 bits, and switching to 16-bit mode cuts the running count.
- R9: The raw flag is set on a step from one to zero. It stays set until a write to word 3, whatever the data written. If a step from one to zero and a clear write fall on the same edge, the flag is set.
- R10: `irq` and the masked status equal the raw flag ANDed with control bit 5. Both are 0 while bit 5 is clear, and the raw status still shows the flag.
- R11: In one-shot mode the counter stays at zero once it gets there. It counts again only after a write to word 0.
- R12: While control bit 7 is clear, the counter holds its value whatever the strobe does.
- R13: A write to word 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-enable strobe, fed to the prescaler |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt, raw flag AND interrupt enable |

## Verification
The assertions assume `bus_addr` and `bus_wdata` are valid whenever `bus_wr` is high. They also assume at most one register is written per edge. This is why the load-capture and one-shot-hold properties can use the previous cycle's write alone. The stimulus changes bus and strobe inputs only on the falling edge, and it writes one word per bus cycle. Sweeps across the prescaler settings and the count position compute each expected counter value as load minus strobes divided by the divider, or as load minus steps modulo the period.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DW    = 32,
  parameter int NW    = 16,
  parameter int AW    = 3,
  parameter int PRE_A = 4,
  parameter int PRE_B = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam logic [DW-1:0] NARROW = {{(DW-NW){1'b0}}, {NW{1'b1}}};
  localparam logic [DW-1:0] ONE    = DW'(1);

  logic [7:0]       ctrl;
  logic [DW-1:0]    ld;
  logic [DW-1:0]    cnt;
  logic             raw;
  logic [PRE_B-1:0] pdiv;

  wire one_shot = ctrl[0];
  wire wide     = ctrl[1];
  wire ie       = ctrl[5];
  wire periodic = ctrl[6];
  wire run      = ctrl[7];

  wire [DW-1:0] mask     = wide ? '1 : NARROW;
  wire [DW-1:0] new_mask = bus_wdata[1] ? '1 : NARROW;
  wire [DW-1:0] cnt_m    = cnt & mask;
  wire [DW-1:0] reload   = periodic ? (ld & mask) : mask;

  wire wr_ld  = bus_wr && bus_addr == AW'(0);
  wire wr_ctl = bus_wr && bus_addr == AW'(2);
  wire wr_clr = bus_wr && bus_addr == AW'(3);
  wire wr_bg  = bus_wr && bus_addr == AW'(6);

  logic pre_hit;
  always_comb begin
    case (ctrl[3:2])
      2'b01:   pre_hit = &pdiv[PRE_A-1:0];
      2'b10:   pre_hit = &pdiv;
      default: pre_hit = 1'b1;
    endcase
  end

  wire tick = cnt_en && pre_hit;
  wire step = run && tick && !wr_ld && !wr_ctl;
  wire hit  = step && cnt_m == ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pdiv <= '0;
    else if (wr_ctl)   pdiv <= '0;
    else if (cnt_en)   pdiv <= pdiv + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl <= 8'h20;
    else if (wr_ctl) ctrl <= bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ld <= '0;
    else if (wr_ld || wr_bg)  ld <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_ld)  cnt <= bus_wdata & mask;
    else if (wr_ctl) cnt <= cnt & new_mask;
    else if (step) begin
      if (cnt_m != '0)    cnt <= cnt_m - ONE;
      else if (!one_shot) cnt <= reload;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      raw <= 1'b0;
    else if (hit)    raw <= 1'b1;
    else if (wr_clr) raw <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      AW'(0), AW'(6): bus_rdata = ld;
      AW'(1):         bus_rdata = cnt_m;
      AW'(2):         bus_rdata = {{(DW-8){1'b0}}, ctrl};
      AW'(4):         bus_rdata = {{(DW-1){1'b0}}, raw};
      AW'(5):         bus_rdata = {{(DW-1){1'b0}}, raw & ie};
      default:        bus_rdata = '0;
    endcase
  end

  assign irq = raw & ie;
endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
  parameter int DW = 32,
  parameter int NW = 16,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] cnt,
  input logic [7:0]    ctrl,
  input logic          raw,
  input logic          irq
);
  localparam logic [DW-1:0] NARROW = {{(DW-NW){1'b0}}, {NW{1'b1}}};

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[7] && !bus_wr) |=> $stable(cnt)); // R12

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[1] |-> (cnt & ~NARROW) == '0); // R8

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (raw && !(bus_wr && bus_addr == AW'(3))) |=> raw); // R9

  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(0)) |=>
      cnt == ($past(bus_wdata) & ($past(ctrl[1]) ? {DW{1'b1}} : NARROW))); // R4

  AST_BG_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(6) && !ctrl[7]) |=> $stable(cnt)); // R5

  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[7] && ctrl[0] && cnt == '0 && !bus_wr) |=> cnt == '0); // R11

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw && ctrl[5])); // R10

  AST_IGNORED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(7)) |=> $stable(ctrl)); // R13
endmodule

bind interval_timer interval_timer_chk #(.DW(DW), .NW(NW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cnt(cnt), .ctrl(ctrl), .raw(raw), .irq(irq)
);

// File: tb/interval_timer_tb.sv
`timescale 1ns/1ps
module interval_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  interval_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt_en = 1'b1;
    end
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd2, v); chk("R1 ctrl", v, 32'h20);
    rd(3'd1, v); chk("R1 count", v, 0);
    rd(3'd0, v); chk("R1 load", v, 0);
    rd(3'd4, v); chk("R1 raw", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R3 prescaler sweep, 32-bit periodic, load 1000
    for (int p = 0; p < 4; p++) begin
      int dv;
      dv = (p == 1) ? 16 : (p == 2) ? 256 : 1;
      for (int k = 0; k < 3; k++) begin
        int n;
        n = (k == 0) ? dv - 1 : (k == 1) ? dv : 2 * dv + 3;
        wr(3'd2, 32'hC2 | (p << 2));
        wr(3'd0, 32'd1000);
        strobe(n);
        rd(3'd1, v);
        chk($sformatf("R3 pre=%0d n=%0d", p, n), v, 32'd1000 - n / dv);
      end
    end

    // R7 periodic sweep: load 5 gives period 6
    for (int n = 0; n <= 13; n++) begin
      wr(3'd2, 32'hC2);
      wr(3'd0, 32'd5);
      strobe(n);
      rd(3'd1, v);
      chk($sformatf("R7 n=%0d", n), v, 32'd5 - n % 6);
    end

    // R6 free-running wrap, 16-bit then 32-bit; R9 raw set
    wr(3'd3, 0);
    wr(3'd2, 32'hA0);
    wr(3'd0, 32'd3);
    strobe(3);
    rd(3'd1, v); chk("R6 at zero", v, 0);
    rd(3'd4, v); chk("R9 raw set", v, 1);
    chk("R10 irq high", {31'd0, irq}, 1);
    strobe(1);
    rd(3'd1, v); chk("R6 wrap16", v, 32'hFFFF);
    wr(3'd2, 32'hA2);
    wr(3'd0, 32'd2);
    strobe(3);
    rd(3'd1, v); chk("R6 wrap32", v, 32'hFFFF_FFFF);

    // R9 sticky and cleared by any write to word 3
    strobe(4);
    rd(3'd4, v); chk("R9 sticky", v, 1);
    wr(3'd3, 32'h1234);
    rd(3'd4, v); chk("R9 cleared", v, 0);

    // R10 masking with interrupt enable clear
    wr(3'd2, 32'h82);
    wr(3'd0, 32'd1);
    strobe(1);
    rd(3'd4, v); chk("R10 raw", v, 1);
    rd(3'd5, v); chk("R10 masked", v, 0);
    chk("R10 irq low", {31'd0, irq}, 0);
    wr(3'd2, 32'h22);
    rd(3'd5, v); chk("R10 masked on", v, 1);
    wr(3'd3, 0);

    // R5 deferred load and ignored counter writes
    wr(3'd2, 32'hC2);
    wr(3'd0, 32'd5);
    wr(3'd6, 32'd9);
    rd(3'd1, v); chk("R5 count kept", v, 5);
    rd(3'd0, v); chk("R2 word0 reads reload", v, 9);
    rd(3'd6, v); chk("R2 word6 reads reload", v, 9);
    wr(3'd1, 32'd77);
    rd(3'd1, v); chk("R5 count write ignored", v, 5);
    strobe(6);
    rd(3'd1, v); chk("R5 new reload at wrap", v, 9);
    rd(3'd3, v); chk("R2 word3 reads zero", v, 0);
    rd(3'd7, v); chk("R2 word7 reads zero", v, 0);

    // R8 16-bit cut
    wr(3'd2, 32'h80);
    wr(3'd0, 32'h1234_5678);
    rd(3'd1, v); chk("R8 load cut", v, 32'h5678);
    wr(3'd2, 32'h82);
    wr(3'd0, 32'hABCD_EF01);
    wr(3'd2, 32'h80);
    rd(3'd1, v); chk("R8 switch cut", v, 32'hEF01);
    wr(3'd2, 32'h82);
    rd(3'd1, v); chk("R8 stays cut", v, 32'hEF01);

    // R11 one-shot
    wr(3'd3, 0);
    wr(3'd2, 32'hA3);
    wr(3'd0, 32'd3);
    strobe(10);
    rd(3'd1, v); chk("R11 parked", v, 0);
    rd(3'd4, v); chk("R11 raw", v, 1);
    wr(3'd0, 32'd4);
    strobe(1);
    rd(3'd1, v); chk("R11 restart", v, 3);

    // R12 hold when stopped
    wr(3'd2, 32'h22);
    wr(3'd0, 32'd7);
    strobe(10);
    rd(3'd1, v); chk("R12 hold", v, 7);

    // R13 write to word 7
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd2, v); chk("R13 ctrl", v, 32'h22);
    rd(3'd0, v); chk("R13 load", v, 7);
    rd(3'd1, v); chk("R13 count", v, 7);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule